// File: doc/BRIEF.md
# Machine Status Word Control Unit

This block keeps the processor's 16-bit machine status word and decides when an instruction that needs the numeric coprocessor must trap with exception 7. Only the four low bits hold state: a protected-mode enable, a monitor bit, an emulate bit and a task-switched bit. The upper twelve bits cannot be written and always read as ones, so the word reads FFF0h after reset, which means real address mode.

A load strobe with a 16-bit value writes the word, and the stored word is always present for a store operation. Once set, the protected-mode bit stays set until reset. A task-switch event sets the task-switched bit. The execute stage raises a strobe when it meets a WAIT instruction or a coprocessor escape instruction. The block checks that strobe against the flags as they stood before the cycle's own load, and one cycle later it answers with a single-cycle exception request that carries vector number 7.

Top module: `msw_ctrl_unit`

## Requirements
- R1: After reset the stored word reads FFF0h, the protected-mode output is 0, the exception request is 0 and the vector output is 0.
- R2: A load writes data bit 1 to the monitor flag (word bit 1), data bit 2 to the emulate flag (word bit 2) and data bit 3 to the task-switched flag (word bit 3); the new value is visible in the cycle after the load.
- R3: A load with data bit 0 at 1 sets the protected-mode flag (word bit 0). A later load with data bit 0 at 0 leaves it at 1, and only reset clears it.
- R4: Loaded bits 15..4 are ignored, and word bits 15..4 always read 1.
- R5: A task-switch event sets word bit 3 in the next cycle. If a load happens in the same cycle, bit 3 still ends at 1 and the other bits take the loaded value.
- R6: A WAIT strobe raises the exception request when the monitor flag and the task-switched flag are both 1, and in no other case.
- R7: An escape strobe raises the exception request when the emulate flag or the task-switched flag is 1, and in no other case.
- R8: The exception request is asserted in the cycle after the strobe and lasts one cycle for each strobe cycle. WAIT and escape strobes in the same cycle give one pulse. The vector output is 7 while the request is high and 0 otherwise.
- R9: The protected-mode output always equals word bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Load the status word from ld_data |
| ld_data | input | 16 | Value to load |
| wait_exec | input | 1 | A WAIT instruction is being executed |
| esc_exec | input | 1 | A coprocessor escape instruction is being executed |
| task_sw | input | 1 | A task switch has occurred |
| msw_out | output | 16 | Stored word, for the store operation |
| prot_mode | output | 1 | Protected mode is enabled |
| fault_req | output | 1 | Exception 7 request, one-cycle pulse |
| fault_vec | output | 8 | Vector number, 7 while fault_req is high |

## Verification
The assertions assume that each instruction strobe stands for one instruction in one cycle, and that the flags a strobe is checked against are the registered flags from before that cycle. The bench drives every strobe for exactly one cycle and sets up the flags with a separate load before each strobe, except in the case that deliberately combines a load with a task switch. The sweep resets the block before each of the sixteen low-nibble values, so the sticky protected-mode bit cannot hide the effect of the other flags.

// File: rtl/msw_pkg.sv
package msw_pkg;
    localparam int unsigned FLAG_W = 4;

    typedef struct packed {
        logic ts;   // bit 3 task switched
        logic em;   // bit 2 emulate coprocessor
        logic mp;   // bit 1 monitor coprocessor
        logic pe;   // bit 0 protected mode
    } msw_bits_t;

    function automatic msw_bits_t bits_from_word(input logic [FLAG_W-1:0] w);
        msw_bits_t b;
        b.pe = w[0];
        b.mp = w[1];
        b.em = w[2];
        b.ts = w[3];
        return b;
    endfunction
endpackage

// File: rtl/msw_flags.sv
module msw_flags
    import msw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_en,
    input  logic [FLAG_W-1:0]   ld_low,
    input  logic                task_sw,
    output msw_bits_t           bits_q
);
    msw_bits_t st_d, st_q;

    always_comb begin
        msw_bits_t ld_b;
        ld_b = bits_from_word(ld_low);
        st_d = st_q;
        if (ld_en) begin
            st_d.mp = ld_b.mp;
            st_d.em = ld_b.em;
            st_d.ts = ld_b.ts;
            // protected mode can only be set by a load
            st_d.pe = st_q.pe | ld_b.pe;
        end
        if (task_sw) begin
            st_d.ts = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_q = st_q;
endmodule

// File: rtl/msw_fault_eval.sv
module msw_fault_eval
    import msw_pkg::*;
#(
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned FAULT_VEC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  msw_bits_t         bits,
    input  logic              wait_exec,
    input  logic              esc_exec,
    output logic              fault_req,
    output logic [VEC_W-1:0]  fault_vec
);
    typedef struct packed {
        logic             req;
        logic [VEC_W-1:0] vec;
    } fault_st_t;

    localparam logic [VEC_W-1:0] VEC_VAL = VEC_W'(FAULT_VEC);

    fault_st_t f_d, f_q;

    always_comb begin
        logic wait_hit;
        logic esc_hit;
        wait_hit = wait_exec & bits.mp & bits.ts;
        esc_hit  = esc_exec & (bits.em | bits.ts);
        f_d.req  = wait_hit | esc_hit;
        f_d.vec  = (wait_hit | esc_hit) ? VEC_VAL : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign fault_req = f_q.req;
    assign fault_vec = f_q.vec;
endmodule

// File: rtl/msw_readback.sv
module msw_readback
    import msw_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  msw_bits_t           bits,
    output logic [WORD_W-1:0]   word
);
    localparam int unsigned UPPER_W = WORD_W - FLAG_W;

    assign word[0] = bits.pe;
    assign word[1] = bits.mp;
    assign word[2] = bits.em;
    assign word[3] = bits.ts;

    for (genvar i = 0; i < UPPER_W; i++) begin : g_upper
        assign word[FLAG_W + i] = 1'b1;
    end
endmodule

// File: rtl/msw_ctrl_unit.sv
module msw_ctrl_unit
    import msw_pkg::*;
#(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned FAULT_VEC = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] ld_data,
    input  logic              wait_exec,
    input  logic              esc_exec,
    input  logic              task_sw,
    output logic [WORD_W-1:0] msw_out,
    output logic              prot_mode,
    output logic              fault_req,
    output logic [VEC_W-1:0]  fault_vec
);
    msw_bits_t bits;

    msw_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_low  (ld_data[FLAG_W-1:0]),
        .task_sw (task_sw),
        .bits_q  (bits)
    );

    msw_fault_eval #(
        .VEC_W     (VEC_W),
        .FAULT_VEC (FAULT_VEC)
    ) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .bits      (bits),
        .wait_exec (wait_exec),
        .esc_exec  (esc_exec),
        .fault_req (fault_req),
        .fault_vec (fault_vec)
    );

    msw_readback #(
        .WORD_W (WORD_W)
    ) u_rb (
        .bits (bits),
        .word (msw_out)
    );

    assign prot_mode = bits.pe;
endmodule

// File: rtl/msw_ctrl_chk.sv
module msw_ctrl_chk #(
    parameter int unsigned WORD_W    = 16,
    parameter int unsigned VEC_W     = 8,
    parameter int unsigned FAULT_VEC = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [WORD_W-1:0] ld_data,
    input logic              wait_exec,
    input logic              esc_exec,
    input logic              task_sw,
    input logic [WORD_W-1:0] msw_out,
    input logic              prot_mode,
    input logic              fault_req,
    input logic [VEC_W-1:0]  fault_vec
);
    // R3
    pe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_mode |=> prot_mode);

    // R4
    upper_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &msw_out[WORD_W-1:4]);

    // R5
    ts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> msw_out[3]);

    // R8
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wait_exec || esc_exec) |=> !fault_req);

    // R8
    fault_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> (fault_vec == VEC_W'(FAULT_VEC)));

    // R8
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_req |-> (fault_vec == '0));

    // R9
    pe_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prot_mode == msw_out[0]);

    // R7
    esc_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (esc_exec && (msw_out[2] || msw_out[3])) |=> fault_req);

    // R6
    wait_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_exec && msw_out[1] && msw_out[3]) |=> fault_req);

    wire unused_ok = &{1'b0, ld_en, ld_data};
endmodule

bind msw_ctrl_unit msw_ctrl_chk #(
    .WORD_W    (WORD_W),
    .VEC_W     (VEC_W),
    .FAULT_VEC (FAULT_VEC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_data   (ld_data),
    .wait_exec (wait_exec),
    .esc_exec  (esc_exec),
    .task_sw   (task_sw),
    .msw_out   (msw_out),
    .prot_mode (prot_mode),
    .fault_req (fault_req),
    .fault_vec (fault_vec)
);

// File: tb/tb_msw_ctrl_unit.sv
module tb_msw_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ld_en;
    logic [15:0] ld_data;
    logic        wait_exec;
    logic        esc_exec;
    logic        task_sw;
    logic [15:0] msw_out;
    logic        prot_mode;
    logic        fault_req;
    logic [7:0]  fault_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    msw_ctrl_unit dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
        .wait_exec(wait_exec), .esc_exec(esc_exec), .task_sw(task_sw),
        .msw_out(msw_out), .prot_mode(prot_mode),
        .fault_req(fault_req), .fault_vec(fault_vec)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_en = 0; ld_data = '0; wait_exec = 0; esc_exec = 0; task_sw = 0;
    endtask

    task automatic do_reset();
        rst_n = 0; idle();
        tick(); tick();
        rst_n = 1;
    endtask

    task automatic do_load(input logic [15:0] v);
        ld_en = 1; ld_data = v; tick(); idle();
    endtask

    // one-cycle strobe, then look at the pulse and its end
    task automatic strobe(input bit w, input bit e, input bit exp, input string req);
        wait_exec = w; esc_exec = e; tick(); idle();
        chk(req, {31'd0, fault_req}, {31'd0, exp});
        chk("R8 vec", {24'd0, fault_vec}, exp ? 32'd7 : 32'd0);
        tick();
        chk("R8 width", {31'd0, fault_req}, 32'd0);
    endtask

    initial begin
        idle();
        do_reset();
        chk("R1 word", {16'd0, msw_out}, 32'hFFF0);
        chk("R1 pe", {31'd0, prot_mode}, 32'd0);
        chk("R1 req", {31'd0, fault_req}, 32'd0);
        chk("R1 vec", {24'd0, fault_vec}, 32'd0);

        for (int v = 0; v < 16; v++) begin
            logic [3:0] n;
            logic [15:0] junk;
            n = 4'(v);
            junk = 16'({v, v} * 16'h0135) & 16'hFFF0;
            do_reset();
            do_load(junk | {12'd0, n});
            chk("R2/R4 load", {16'd0, msw_out}, {16'd0, 12'hFFF, n});
            chk("R9 pe", {31'd0, prot_mode}, {31'd0, n[0]});
            strobe(1, 0, n[1] & n[3], "R6 wait");
            strobe(0, 1, n[2] | n[3], "R7 esc");
            strobe(1, 1, (n[1] & n[3]) | n[2] | n[3], "R8 both");
            do_load(16'h0000);
            chk("R3 sticky", {16'd0, msw_out}, {16'd0, 12'hFFF, 3'b000, n[0]});
        end

        // R3 reset clears protected mode
        do_reset();
        do_load(16'h0001);
        chk("R3 set", {31'd0, prot_mode}, 32'd1);
        do_reset();
        chk("R3 reset clears", {16'd0, msw_out}, 32'hFFF0);

        // R5 task switch alone, then with a clearing load
        task_sw = 1; tick(); idle();
        chk("R5 event", {16'd0, msw_out}, 32'hFFF8);
        ld_en = 1; ld_data = 16'h0006; task_sw = 1; tick(); idle();
        chk("R5 priority", {16'd0, msw_out}, 32'hFFFE);
        do_load(16'h0000);
        chk("R5 load clears", {16'd0, msw_out}, 32'hFFF0);

        // R8 back-to-back strobes give two pulses
        do_load(16'h0008);
        esc_exec = 1; tick();
        chk("R8 first", {31'd0, fault_req}, 32'd1);
        tick(); idle();
        chk("R8 second", {31'd0, fault_req}, 32'd1);
        tick();
        chk("R8 end", {31'd0, fault_req}, 32'd0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule